// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block turns a core clock into the SCL waveform of an I2C master and gives the transfer controller the timing strobes it needs for each bit: one strobe telling it when to change SDA and one telling it when to capture SDA. The SCL rate is set by a 16-bit divisor, so one bit takes that many core cycles. The SCL low and high phases take half of it each. Each strobe is placed inside its phase by its own edge delay.

The generator senses the real SCL line. The high phase does not begin counting until the line is really high, so a slave can stretch the clock. If the stretch lasts longer than a programmed number of bit periods, the generator raises a timeout flag. It then freezes with both lines released until the controller clears it. Byte sequencing, data storage and register access belong to the controller around it.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset, and whenever `run_i` has been low since the last clear, `scl_oe_o` is 0 and `sda_drive_o`, `sda_sample_o`, `bit_tick_o` and `stretch_to_o` are all 0.
- R2: Let E be `div_i`, or 32768 when `div_i` is 0, and let H be E/2 rounded down (at least 1). Each low phase (`scl_oe_o`=1) lasts exactly H cycles. Each unstretched high phase lasts H cycles, so one bit is 2H cycles.
- R3: A divisor of 0 gives low phases of 16384 cycles.
- R4: `sda_drive_o` pulses exactly once per low phase, in the low cycle whose index (counted from 0) equals the falling delay, which is `edge_dly_i[31:16]`.
- R5: `sda_sample_o` pulses once per high phase, in the counted high cycle whose index equals the rising delay, which is `edge_dly_i[15:0]`.
- R6: If an edge delay is H or more, H-1 is used instead. With such a delay, the drive strobe falls in the last low cycle, and the sample strobe falls in the same cycle as `bit_tick_o`.
- R7: The high phase starts counting only in a cycle where `scl_i` is 1. While its first cycle sees `scl_i` low, SCL stays released and no sample strobe or tick is given.
- R8: If `stretch_lim_i` is L (not 0) and SCL is held low at the start of a high phase for L·E consecutive cycles, `stretch_to_o` becomes 1 in the next cycle. A hold of L·E-1 cycles raises no flag.
- R9: If `stretch_lim_i` is 0, no stretch, however long, raises `stretch_to_o`.
- R10: After a timeout, `stretch_to_o` stays 1, `scl_oe_o` stays 0 and no strobe is given, until `clr_i` is pulsed. `clr_i` returns the block to idle with the flag cleared.
- R11: `bit_tick_o` pulses in the last high cycle. If `run_i` is 1 in that cycle, the next cycle begins a new low phase. Otherwise SCL stays released.
- R12: `sda_oe_o` follows `sda_low_i` in every state except the timeout state, where it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous return to idle; clears a timeout |
| run_i | input | 1 | Keep generating bits |
| div_i | input | 16 | Bit period in core cycles; 0 selects 32768 |
| edge_dly_i | input | 32 | [31:16] falling delay, [15:0] rising delay, in core cycles |
| stretch_lim_i | input | 16 | Stretch limit in bit periods; 0 disables it |
| scl_i | input | 1 | Sensed SCL line level |
| sda_low_i | input | 1 | Controller wants SDA pulled low |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |
| sda_drive_o | output | 1 | Strobe: change SDA now |
| sda_sample_o | output | 1 | Strobe: capture SDA now |
| bit_tick_o | output | 1 | Strobe: last cycle of a bit |
| stretch_to_o | output | 1 | Stretch timeout flag |

## Verification
Two pairs of events can fall in the same cycle. When the rising delay is clamped, the sample strobe lands on the bit tick. When the falling delay is clamped, the drive strobe lands on the low-to-high handover. The bench forces both cases with delays larger than half the divisor, alongside random delays that often exceed it. In the cycle of the bit tick it requires the sample strobe to be present as well, and in the cycle after the drive strobe it requires SCL to be released. A cycle-accurate model in the bench judges every output in every cycle. The model also covers a third overlap, where the stretch limit expires in a cycle that would otherwise have ended the stall.

// File: rtl/i2c_tm_pkg.sv
package i2c_tm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2,
    PH_LOCK = 2'd3
  } phase_e;
endpackage

// File: rtl/i2c_tm_cfg.sv
module i2c_tm_cfg #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] div_i,
  input  logic [2*DW-1:0] dly_i,
  output logic [DW-1:0] per_o,
  output logic [DW-1:0] half_o,
  output logic [DW-1:0] fall_o,
  output logic [DW-1:0] rise_o
);
  localparam logic [DW-1:0] ZERO_DIV = DW'(1) << (DW-1);

  logic [DW-1:0] half_raw, fall_raw, rise_raw;

  assign per_o    = (div_i == '0) ? ZERO_DIV : div_i;
  assign half_raw = per_o >> 1;
  assign half_o   = (half_raw == '0) ? DW'(1) : half_raw;
  assign fall_raw = dly_i[2*DW-1:DW];
  assign rise_raw = dly_i[DW-1:0];
  assign fall_o   = (fall_raw >= half_o) ? half_o - DW'(1) : fall_raw;
  assign rise_o   = (rise_raw >= half_o) ? half_o - DW'(1) : rise_raw;

  a_r6_fall_in_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o < half_o);
  a_r6_rise_in_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o < half_o);
  a_r2_half_le_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_o != '0) && (half_o <= per_o));
endmodule

// File: rtl/i2c_tm_stretch.sv
module i2c_tm_stretch #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          stall_i,
  input  logic [DW-1:0] per_i,
  input  logic [DW-1:0] lim_i,
  output logic          expire_o
);
  logic [DW-1:0] cyc_q, prd_q;
  logic          prd_end;

  assign prd_end  = (cyc_q == per_i - DW'(1));
  assign expire_o = stall_i && (lim_i != '0) && prd_end &&
                    (({1'b0, prd_q} + (DW+1)'(1)) == {1'b0, lim_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      prd_q <= '0;
    end else if (clr_i || !stall_i) begin
      cyc_q <= '0;
      prd_q <= '0;
    end else if (prd_end) begin
      cyc_q <= '0;
      prd_q <= prd_q + DW'(1);
    end else begin
      cyc_q <= cyc_q + DW'(1);
    end
  end

  a_r9_zero_limit_never_expires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_i == '0) |-> !expire_o);
  a_r8_expire_needs_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> stall_i);
endmodule

// File: rtl/i2c_tm_phase.sv
module i2c_tm_phase
  import i2c_tm_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic          scl_i,
  input  logic [DW-1:0] half_i,
  input  logic [DW-1:0] fall_i,
  input  logic [DW-1:0] rise_i,
  input  logic          expire_i,
  output phase_e        phase_o,
  output logic          stall_o,
  output logic          scl_oe_o,
  output logic          drive_o,
  output logic          sample_o,
  output logic          tick_o
);
  phase_e        ph_q;
  logic [DW-1:0] cnt_q;
  logic          last, adv;

  assign last     = (cnt_q == half_i - DW'(1));
  // high phase holds at count 0 until the line is really high
  assign stall_o  = (ph_q == PH_HIGH) && (cnt_q == '0) && !scl_i;
  assign adv      = (ph_q == PH_HIGH) && !stall_o;
  assign scl_oe_o = (ph_q == PH_LOW);
  assign drive_o  = (ph_q == PH_LOW) && (cnt_q == fall_i);
  assign sample_o = adv && (cnt_q == rise_i);
  assign tick_o   = adv && last;
  assign phase_o  = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (clr_i) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (run_i) begin
          ph_q  <= PH_LOW;
          cnt_q <= '0;
        end
        PH_LOW: if (last) begin
          ph_q  <= PH_HIGH;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + DW'(1);
        end
        PH_HIGH: if (expire_i) begin
          ph_q  <= PH_LOCK;
          cnt_q <= '0;
        end else if (!stall_o) begin
          if (last) begin
            ph_q  <= run_i ? PH_LOW : PH_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + DW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  a_r10_lock_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_LOCK) && !clr_i |=> (ph_q == PH_LOCK));
  a_r10_lock_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_LOCK) |-> !scl_oe_o && !drive_o && !sample_o && !tick_o);
  a_r8_expire_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i && !clr_i |=> (ph_q == PH_LOCK));
  a_r7_no_strobe_in_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !sample_o && !tick_o && !scl_oe_o);
  a_r4_drive_while_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o |-> scl_oe_o);
  a_r11_tick_then_low_or_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && !clr_i |=> (ph_q == PH_LOW) || (ph_q == PH_IDLE));
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
  import i2c_tm_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            run_i,
  input  logic [DW-1:0]   div_i,
  input  logic [2*DW-1:0] edge_dly_i,
  input  logic [DW-1:0]   stretch_lim_i,
  input  logic            scl_i,
  input  logic            sda_low_i,
  output logic            scl_oe_o,
  output logic            sda_oe_o,
  output logic            sda_drive_o,
  output logic            sda_sample_o,
  output logic            bit_tick_o,
  output logic            stretch_to_o
);
  logic [DW-1:0] per, half, fall, rise;
  logic          stall, expire;
  phase_e        phase;

  i2c_tm_cfg #(.DW(DW)) u_cfg (
    .clk_i, .rst_ni, .div_i, .dly_i(edge_dly_i),
    .per_o(per), .half_o(half), .fall_o(fall), .rise_o(rise)
  );

  i2c_tm_stretch #(.DW(DW)) u_stretch (
    .clk_i, .rst_ni, .clr_i, .stall_i(stall), .per_i(per),
    .lim_i(stretch_lim_i), .expire_o(expire)
  );

  i2c_tm_phase #(.DW(DW)) u_phase (
    .clk_i, .rst_ni, .clr_i, .run_i, .scl_i,
    .half_i(half), .fall_i(fall), .rise_i(rise), .expire_i(expire),
    .phase_o(phase), .stall_o(stall), .scl_oe_o,
    .drive_o(sda_drive_o), .sample_o(sda_sample_o), .tick_o(bit_tick_o)
  );

  assign stretch_to_o = (phase == PH_LOCK);
  assign sda_oe_o     = sda_low_i && !stretch_to_o;

  a_r12_timeout_releases_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stretch_to_o |-> !sda_oe_o && !scl_oe_o);
  a_r10_flag_clears_on_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !stretch_to_o);
endmodule

// File: tb/i2c_scl_timer_test.sv
module i2c_scl_timer_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, clr, run, hold, sda_low;
  logic [15:0] div, lim;
  logic [31:0] dly;
  logic scl_oe, sda_oe, drv, smp, tick, sto;
  logic scl_line;

  assign scl_line = !scl_oe && !hold;

  i2c_scl_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .run_i(run), .div_i(div),
    .edge_dly_i(dly), .stretch_lim_i(lim), .scl_i(scl_line), .sda_low_i(sda_low),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .sda_drive_o(drv), .sda_sample_o(smp),
    .bit_tick_o(tick), .stretch_to_o(sto)
  );

  int checks = 0, errors = 0, cycles = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int f_eff(input logic [15:0] d);
    return (d == 0) ? 32768 : int'(d);
  endfunction
  function automatic int f_half(input logic [15:0] d);
    int h = f_eff(d) / 2;
    return (h < 1) ? 1 : h;
  endfunction
  function automatic int f_clamp(input int v, input int h);
    return (v >= h) ? h - 1 : v;
  endfunction

  // cycle model: 0 idle, 1 low, 2 high, 3 timed out
  int     m_ph = 0, m_cnt = 0;
  longint m_st = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_st = 0;
    end else begin
      int h, fd, rd;
      bit stall, adv;
      h  = f_half(div);
      fd = f_clamp(int'(dly[31:16]), h);
      rd = f_clamp(int'(dly[15:0]), h);
      stall = (m_ph == 2) && (m_cnt == 0) && !scl_line;
      adv   = (m_ph == 2) && !stall;
      chk(scl_oe == (m_ph == 1), "R2 scl_oe", scl_oe, m_ph == 1);
      chk(drv == ((m_ph == 1) && (m_cnt == fd)), "R4 drive", drv, (m_ph == 1) && (m_cnt == fd));
      chk(smp == (adv && (m_cnt == rd)), "R5 sample", smp, adv && (m_cnt == rd));
      chk(tick == (adv && (m_cnt == h - 1)), "R11 tick", tick, adv && (m_cnt == h - 1));
      chk(sto == (m_ph == 3), "R8 timeout flag", sto, m_ph == 3);
      chk(sda_oe == (sda_low && (m_ph != 3)), "R12 sda_oe", sda_oe, sda_low && (m_ph != 3));
      if (clr) begin
        m_ph = 0; m_cnt = 0; m_st = 0;
      end else begin
        case (m_ph)
          0: if (run) begin m_ph = 1; m_cnt = 0; end
          1: if (m_cnt == h - 1) begin m_ph = 2; m_cnt = 0; end else m_cnt++;
          2: if (stall) begin
               if (lim != 0 && m_st + 1 == longint'(lim) * f_eff(div)) begin
                 m_ph = 3; m_cnt = 0; m_st = 0;
               end else m_st++;
             end else begin
               m_st = 0;
               if (m_cnt == h - 1) begin m_ph = run ? 1 : 0; m_cnt = 0; end
               else m_cnt++;
             end
          default: ;
        endcase
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cfg_set(input int d, input int f, input int r, input int l);
    @(posedge clk); #1;
    div = 16'(d); dly = {16'(f), 16'(r)}; lim = 16'(l); clr = 1'b1;
    @(posedge clk); #1;
    clr = 1'b0;
  endtask

  task automatic wait_oe(input bit v);
    @(negedge clk);
    while (scl_oe != v) @(negedge clk);
  endtask

  initial begin
    int n, s;
    s = $urandom(1234);
    rst_n = 0; clr = 0; run = 0; hold = 0; sda_low = 0;
    div = 16'd10; dly = 0; lim = 0;
    step(3);
    rst_n = 1;
    @(negedge clk);
    chk(!scl_oe && !drv && !smp && !tick && !sto, "R1 idle after reset",
        {scl_oe, drv, smp, tick, sto}, 0);
    step(5);
    @(negedge clk);
    chk(!scl_oe && !sto, "R1 idle without run", {scl_oe, sto}, 0);

    // R2 phase lengths, div 10 -> 5 + 5
    cfg_set(10, 2, 3, 4);
    run = 1;
    wait_oe(1);
    n = 0;
    while (scl_oe) begin n++; @(negedge clk); end
    chk(n == 5, "R2 low phase length", n, 5);
    n = 0;
    while (!scl_oe) begin n++; @(negedge clk); end
    chk(n == 5, "R2 high phase length", n, 5);

    // R6 clamped delays: sample with tick, drive on last low cycle
    cfg_set(8, 9, 4, 0);
    @(negedge clk);
    while (!tick) @(negedge clk);
    chk(smp, "R6 sample coincides with tick", smp, 1);
    @(negedge clk);
    while (!drv) @(negedge clk);
    @(negedge clk);
    chk(!scl_oe, "R6 drive on last low cycle", scl_oe, 0);

    // R7/R8 stretch just under limit (2*6-1 cycles)
    cfg_set(6, 1, 1, 2);
    wait_oe(1);
    @(posedge clk); #1; hold = 1;
    wait_oe(0);
    chk(!smp && !tick && !scl_oe, "R7 stalled high phase quiet", {smp, tick, scl_oe}, 0);
    step(11);
    hold = 0;
    step(3);
    @(negedge clk);
    chk(!sto, "R8 no timeout at limit-1", sto, 0);
    // stretch for the full limit
    wait_oe(1);
    @(posedge clk); #1; hold = 1;
    wait_oe(0);
    step(12);
    hold = 0;
    @(negedge clk);
    chk(sto, "R8 timeout raised", sto, 1);
    step(20);
    @(negedge clk);
    chk(sto && !scl_oe && !drv && !tick, "R10 timeout sticky", {sto, scl_oe}, 2);
    @(posedge clk); #1; clr = 1;
    @(posedge clk); #1; clr = 0;
    @(negedge clk);
    chk(!sto, "R10 clr clears flag", sto, 0);

    // R9 limit zero never times out
    cfg_set(4, 0, 0, 0);
    wait_oe(1);
    @(posedge clk); #1; hold = 1;
    step(300);
    @(negedge clk);
    chk(!sto && !scl_oe, "R9 disabled limit", {sto, scl_oe}, 0);
    @(posedge clk); #1; hold = 0;
    step(10);

    // random configurations
    for (int it = 0; it < 30; it++) begin
      cfg_set($urandom_range(1, 40), $urandom_range(0, 25), $urandom_range(0, 25),
              $urandom_range(0, 3));
      run = ($urandom_range(0, 3) != 0);
      for (int c = 0; c < 60; c++) begin
        @(posedge clk); #1;
        hold    = ($urandom_range(0, 5) == 0);
        sda_low = 1'($urandom_range(0, 1));
        if ($urandom_range(0, 15) == 0) run = ~run;
      end
    end
    hold = 0;

    // R3 zero divisor
    cfg_set(0, 0, 0, 0);
    run = 1;
    wait_oe(1);
    n = 0;
    while (scl_oe) begin n++; @(negedge clk); end
    chk(n == 16384, "R3 zero divisor low phase", n, 16384);
    run = 0;
    step(20);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule